// File: doc/BRIEF.md
# Line-Locked Reference Selector and Phase-Frequency Detector

This block is the digital front end of a clock synthesizer that can lock its output clock to a video line rate. It picks a reference event stream from one of two sources. The first is a horizontal sync input, on an edge of selectable polarity. The second is an oscillator input divided by a programmable modulus. A fed-back copy of the synthesized clock is divided by a second programmable modulus. A tri-state phase-frequency detector compares the two event streams. It issues up pulses when the reference leads and down pulses when the feedback leads, and an analog charge pump downstream consumes them. A vertical sync input can open a coast window. While the window is open the detector is held empty and emits nothing, so the loop keeps its last correction.

All inputs are sampled on the fast system clock `clk` through synchronizer stages of equal depth, so the two compared paths have the same latency. Configuration fields arrive already committed. The divider moduli are taken up only at reset or on a one-cycle `load_i` strobe, which also restarts both dividers. The block has no data stream. Its outputs are plain single-bit strobes and levels, with no valid/ready handshake and no back-pressure: the downstream pump must act on every cycle in which `up_o` or `dn_o` is high.

Top module: `llpd_front`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `up_o`, `dn_o`, `ref_pulse_o` and `fb_pulse_o` are all 0.
- R2: The feedback modulus is N = `fb_word_i` + 8. After reset or a load, `fb_pulse_o` is high for exactly one cycle on the N-th rising edge of `fb_clk_i`, and again on every N-th rising edge after that.
- R3: The oscillator modulus is M = `osc_word_i` + 2. When `ref_sel_i` = 1, `ref_pulse_o` is high for one cycle on every M-th rising edge of `osc_i`, counted from reset or a load.
- R4: When `ref_sel_i` = 0, each selected `hsync_i` edge is a reference event and `osc_i` produces none. When `ref_sel_i` = 1, `hsync_i` edges produce no reference event.
- R5: `hs_fall_i` = 0 makes rising `hsync_i` edges the reference events. `hs_fall_i` = 1 makes falling edges the reference events. The opposite edge is ignored in each case.
- R6: If a reference event is d > 0 cycles ahead of a feedback event, `up_o` is high for exactly d consecutive cycles and `dn_o` stays low. If the two events fall in the same cycle, neither output pulses.
- R7: If a feedback event is d > 0 cycles ahead of a reference event, `dn_o` is high for exactly d consecutive cycles and `up_o` stays low.
- R8: Coast applies when `cp_always_i` = 0 and the synchronized `vsync_i` equals `vs_coast_high_i` (0: coast while vsync is low, 1: coast while it is high). During coast, `up_o` and `dn_o` are 0 and events are discarded. A pulse under way is cut off, and no pulse resumes when coast ends. When `cp_always_i` = 1, `vsync_i` has no effect.
- R9: Changes to `fb_word_i` or `osc_word_i` have no effect until `load_i`. A load restarts the count, so the first period after it is a full period of the new modulus.
- R10: A word below the legal minimum is treated as the minimum modulus: 12 for the feedback divider and 3 for the oscillator divider.
- R11: `up_o` and `dn_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset; takes up the moduli |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| vsync_i | input | 1 | Vertical sync, asynchronous; drives the coast window |
| osc_i | input | 1 | Oscillator input, asynchronous |
| fb_clk_i | input | 1 | Fed-back synthesized clock, asynchronous |
| fb_word_i | input | 12 | Feedback divider word (modulus = word + 8) |
| osc_word_i | input | 7 | Oscillator divider word (modulus = word + 2) |
| load_i | input | 1 | One-cycle strobe: take up the words and restart both dividers |
| ref_sel_i | input | 1 | 0: horizontal sync reference, 1: divided oscillator |
| hs_fall_i | input | 1 | 0: rising sync edge, 1: falling sync edge |
| cp_always_i | input | 1 | 1: pump always enabled, 0: coast gated by vsync |
| vs_coast_high_i | input | 1 | Coast level of vsync (0 low, 1 high) |
| ref_pulse_o | output | 1 | One-cycle reference event strobe |
| fb_pulse_o | output | 1 | One-cycle feedback event strobe |
| up_o | output | 1 | Charge-pump up request |
| dn_o | output | 1 | Charge-pump down request |

## Verification
The assertions assume that each asynchronous input holds every level for at least two `clk` cycles, so that an edge strobe is never followed by another in the next cycle. They also assume that `hs_fall_i` and the divider words change only while the inputs are idle, with the words followed by a load. The stimulus holds every sync, oscillator and feedback level for at least three cycles. It changes configuration only between event groups, after waiting out the synchronizer depth. Phase errors are created by placing the selected sync edge and the N-th feedback edge a known number of cycles apart. Because both paths have the same latency, the expected pulse width equals that offset.

// File: rtl/llpd_pkg.sv
package llpd_pkg;

  // Default depth of the input synchronizers (two metastability stages).
  localparam int unsigned LLPD_SYNC_DEFAULT = 2;

  // Detector state: one flag per direction.
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_flags_t;

endpackage

// File: rtl/llpd_edge.sv
module llpd_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic fall,
  output logic strobe
);

  logic [STAGES:0] pipe_q;
  logic            cur;
  logic            prev;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[STAGES-1:0], din};
  end

  assign cur    = pipe_q[STAGES-1];
  assign prev   = pipe_q[STAGES];
  assign strobe = fall ? (prev & ~cur) : (cur & ~prev);

  // R5: with a steady polarity, one edge strobe is never followed by another.
  a_r5_strobe_isolated: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (!strobe || (fall != $past(fall))));

endmodule

// File: rtl/llpd_moddiv.sv
module llpd_moddiv #(
  parameter int unsigned W   = 12,
  parameter int unsigned OFF = 8,
  parameter int unsigned MIN = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         tick,
  output logic         pulse
);

  localparam int unsigned CW = $clog2((1 << W) + OFF);

  logic [CW-1:0] raw_mod;
  logic [CW-1:0] new_mod;
  logic [CW-1:0] mod_q;
  logic [CW-1:0] cnt_q;

  assign raw_mod = CW'(word) + CW'(OFF);
  assign new_mod = (raw_mod < CW'(MIN)) ? CW'(MIN) : raw_mod;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      mod_q <= new_mod;
      cnt_q <= new_mod - CW'(1);
    end else if (tick) begin
      if (cnt_q == '0) cnt_q <= mod_q - CW'(1);
      else             cnt_q <= cnt_q - CW'(1);
    end
  end

  assign pulse = tick & (cnt_q == '0) & ~load & ~rst;

  // R2 / R3: the remaining count always stays below the active modulus.
  a_r2_cnt_below_mod: assert property (@(posedge clk) disable iff (rst)
    cnt_q < mod_q);

  // R10: the active modulus never drops under the legal floor.
  a_r10_mod_floor: assert property (@(posedge clk) disable iff (rst)
    mod_q >= CW'(MIN));

  // R9: without a load the modulus is held from cycle to cycle.
  a_r9_mod_held: assert property (@(posedge clk) disable iff (rst)
    !load |=> (mod_q == $past(mod_q)));

endmodule

// File: rtl/llpd_pfd.sv
module llpd_pfd
  import llpd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_s,
  input  logic fb_s,
  input  logic coast,
  output logic up_o,
  output logic dn_o
);

  pfd_flags_t flg_q;
  pfd_flags_t flg_d;

  always_comb begin
    flg_d.up = flg_q.up | ref_s;
    flg_d.dn = flg_q.dn | fb_s;
    if (coast || (flg_d.up && flg_d.dn)) flg_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flg_q <= '0;
    else     flg_q <= flg_d;
  end

  assign up_o = flg_q.up & ~coast;
  assign dn_o = flg_q.dn & ~coast;

  // R11: the two requests are mutually exclusive.
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(up_o && dn_o));

  // R8: a coast cycle leaves the detector empty afterwards.
  a_r8_coast_clears: assert property (@(posedge clk) disable iff (rst)
    coast |=> (!flg_q.up && !flg_q.dn));

  // R6: an up request only starts right after a reference event.
  a_r6_up_after_ref: assert property (@(posedge clk) disable iff (rst)
    $rose(up_o) |-> $past(ref_s));

  // R7: a down request only starts right after a feedback event.
  a_r7_dn_after_fb: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_o) |-> $past(fb_s));

endmodule

// File: rtl/llpd_front.sv
module llpd_front #(
  parameter int unsigned SYNC_STAGES = llpd_pkg::LLPD_SYNC_DEFAULT,
  parameter int unsigned FB_W        = 12,
  parameter int unsigned FB_OFF      = 8,
  parameter int unsigned FB_MIN      = 12,
  parameter int unsigned OSC_W       = 7,
  parameter int unsigned OSC_OFF     = 2,
  parameter int unsigned OSC_MIN     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             osc_i,
  input  logic             fb_clk_i,
  input  logic [FB_W-1:0]  fb_word_i,
  input  logic [OSC_W-1:0] osc_word_i,
  input  logic             load_i,
  input  logic             ref_sel_i,
  input  logic             hs_fall_i,
  input  logic             cp_always_i,
  input  logic             vs_coast_high_i,
  output logic             ref_pulse_o,
  output logic             fb_pulse_o,
  output logic             up_o,
  output logic             dn_o
);

  localparam int unsigned NEDGE  = 3;
  localparam int unsigned IX_HS  = 0;
  localparam int unsigned IX_OSC = 1;
  localparam int unsigned IX_FB  = 2;

  logic [NEDGE-1:0] e_din;
  logic [NEDGE-1:0] e_fall;
  logic [NEDGE-1:0] e_str;

  assign e_din  = {fb_clk_i, osc_i, hsync_i};
  assign e_fall = {1'b0, 1'b0, hs_fall_i};

  // Equal-depth synchronizer and edge strobe for every event input.
  for (genvar g = 0; g < NEDGE; g++) begin : g_edge
    llpd_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .din    (e_din[g]),
      .fall   (e_fall[g]),
      .strobe (e_str[g])
    );
  end

  // Vertical sync is used as a level only.
  logic [SYNC_STAGES-1:0] vs_pipe_q;
  logic                   vs_lvl;

  always_ff @(posedge clk) begin
    if (rst) vs_pipe_q <= '0;
    else     vs_pipe_q <= {vs_pipe_q[SYNC_STAGES-2:0], vsync_i};
  end
  assign vs_lvl = vs_pipe_q[SYNC_STAGES-1];

  logic osc_div_pulse;
  logic coast;

  llpd_moddiv #(.W(OSC_W), .OFF(OSC_OFF), .MIN(OSC_MIN)) u_osc_div (
    .clk   (clk),
    .rst   (rst),
    .load  (load_i),
    .word  (osc_word_i),
    .tick  (e_str[IX_OSC]),
    .pulse (osc_div_pulse)
  );

  llpd_moddiv #(.W(FB_W), .OFF(FB_OFF), .MIN(FB_MIN)) u_fb_div (
    .clk   (clk),
    .rst   (rst),
    .load  (load_i),
    .word  (fb_word_i),
    .tick  (e_str[IX_FB]),
    .pulse (fb_pulse_o)
  );

  assign ref_pulse_o = ref_sel_i ? osc_div_pulse : e_str[IX_HS];
  assign coast       = ~cp_always_i & (vs_lvl == vs_coast_high_i);

  llpd_pfd u_pfd (
    .clk   (clk),
    .rst   (rst),
    .ref_s (ref_pulse_o),
    .fb_s  (fb_pulse_o),
    .coast (coast),
    .up_o  (up_o),
    .dn_o  (dn_o)
  );

  // R1: no output activity in the first cycle after reset.
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!up_o && !dn_o && !ref_pulse_o && !fb_pulse_o));

endmodule

// File: tb/test_llpd_front.sv
module test_llpd_front;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync = 1'b0, vsync = 1'b1, osc = 1'b0, fb_clk = 1'b0;
  logic [11:0] fb_word = 12'd4;
  logic [6:0]  osc_word = 7'd1;
  logic        load = 1'b0, ref_sel = 1'b0, hs_fall = 1'b0;
  logic        cp_always = 1'b1, vs_coast_high = 1'b0;
  logic        ref_pulse, fb_pulse, up, dn;

  always #5 clk = ~clk;

  llpd_front i_llpd_front (
    .clk(clk), .rst(rst), .hsync_i(hsync), .vsync_i(vsync), .osc_i(osc),
    .fb_clk_i(fb_clk), .fb_word_i(fb_word), .osc_word_i(osc_word),
    .load_i(load), .ref_sel_i(ref_sel), .hs_fall_i(hs_fall),
    .cp_always_i(cp_always), .vs_coast_high_i(vs_coast_high),
    .ref_pulse_o(ref_pulse), .fb_pulse_o(fb_pulse), .up_o(up), .dn_o(dn)
  );

  int n_chk = 0, n_fail = 0;
  int ref_cnt = 0, fb_cnt = 0;
  bit mute = 1'b1;

  typedef struct { int signed_width; string req; } exp_t;
  exp_t sbq[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: counts strobes and measures every up/dn run (up positive, dn negative).
  int run_len = 0;
  bit run_up  = 1'b0;
  always begin
    exp_t e;
    @(posedge clk); #1;
    if (!rst) begin
      ref_cnt += int'(ref_pulse);
      fb_cnt  += int'(fb_pulse);
      if (up && dn) check(1'b0, "R11", "up and dn together", 1, 0);
      if (up || dn) begin
        if (run_len == 0) run_up = up;
        run_len++;
      end else if (run_len != 0) begin
        if (!mute) begin
          if (sbq.size() == 0)
            check(1'b0, "R8", "unexpected pulse (signed width)", run_up ? run_len : -run_len, 0);
          else begin
            e = sbq.pop_front();
            check((run_up ? run_len : -run_len) == e.signed_width, e.req,
                  "pulse signed width", run_up ? run_len : -run_len, e.signed_width);
          end
        end
        run_len = 0;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fb_edge();
    fb_clk = 1'b1; tick(3); fb_clk = 1'b0; tick(3);
  endtask

  task automatic osc_edge();
    osc = 1'b1; tick(3); osc = 1'b0; tick(3);
  endtask

  task automatic do_load();
    tick(4); load = 1'b1; tick(1); load = 1'b0; tick(2);
  endtask

  task automatic clear_pfd();
    bit keep_cp = cp_always, keep_vh = vs_coast_high, keep_vs = vsync;
    cp_always = 1'b0; vs_coast_high = 1'b0; vsync = 1'b0; tick(6);
    cp_always = keep_cp; vs_coast_high = keep_vh; vsync = keep_vs; tick(6);
  endtask

  // Driver: places the selected sync edge d cycles ahead of the 12th feedback
  // edge (negative d: feedback first) and pushes the expected pulse.
  task automatic phase_event(int d, bit expect_pulse, string req);
    exp_t e;
    hsync = hs_fall; tick(5);
    do_load();
    repeat (11) fb_edge();
    if (expect_pulse && d != 0) begin
      e.signed_width = d; e.req = req;
      sbq.push_back(e);
    end
    if (d >= 0) begin
      hsync = ~hs_fall; tick(d); fb_clk = 1'b1; tick(4);
    end else begin
      fb_clk = 1'b1; tick(-d); hsync = ~hs_fall; tick(4);
    end
    fb_clk = 1'b0; hsync = hs_fall; tick(8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base;
    tick(3);
    check(!up && !dn && !ref_pulse && !fb_pulse, "R1", "outputs in reset",
          {up, dn, ref_pulse, fb_pulse}, 0);
    tick(2); rst = 1'b0; tick(1);
    check(!up && !dn && !ref_pulse && !fb_pulse, "R1", "outputs after reset",
          {up, dn, ref_pulse, fb_pulse}, 0);
    mute = 1'b0;

    // Phase comparison, rising sync edge
    phase_event(3, 1'b1, "R6");
    phase_event(9, 1'b1, "R6");
    phase_event(0, 1'b1, "R6");
    phase_event(-4, 1'b1, "R7");
    phase_event(-1, 1'b1, "R7");
    // Falling sync edge as reference
    hs_fall = 1'b1; tick(6);
    phase_event(5, 1'b1, "R5");
    phase_event(-2, 1'b1, "R5");
    hs_fall = 1'b0; hsync = 1'b0; tick(6);

    // Coast windows
    cp_always = 1'b0; vs_coast_high = 1'b0; vsync = 1'b0; tick(6);
    phase_event(5, 1'b0, "R8");
    vsync = 1'b1; tick(6);
    phase_event(3, 1'b1, "R8");
    vs_coast_high = 1'b1; tick(6);
    phase_event(-6, 1'b0, "R8");
    vsync = 1'b0; tick(6);
    phase_event(-2, 1'b1, "R8");
    cp_always = 1'b1; vsync = 1'b1; tick(6);
    phase_event(4, 1'b1, "R8");
    vs_coast_high = 1'b0; tick(4);

    // Coast cutting a pulse in progress
    mute = 1'b1;
    cp_always = 1'b0; vsync = 1'b1; tick(6);
    do_load();
    repeat (11) fb_edge();
    hsync = 1'b1; tick(6);
    check(up == 1'b1, "R8", "up before coast", up, 1);
    vsync = 1'b0; tick(5);
    check(up == 1'b0 && dn == 1'b0, "R8", "up cut by coast", {up, dn}, 0);
    fb_edge(); hsync = 1'b0; tick(3);
    vsync = 1'b1; tick(6);
    check(up == 1'b0 && dn == 1'b0, "R8", "no resume after coast", {up, dn}, 0);
    cp_always = 1'b1; tick(4);

    // Feedback divider (monitor muted: reference stays idle)
    fb_word = 12'd4; do_load(); fb_cnt = 0;
    repeat (11) fb_edge(); tick(3);
    check(fb_cnt == 0, "R2", "fb pulses after 11 edges", fb_cnt, 0);
    fb_edge(); tick(3);
    check(fb_cnt == 1, "R2", "fb pulses after 12 edges", fb_cnt, 1);
    repeat (12) fb_edge(); tick(3);
    check(fb_cnt == 2, "R2", "fb pulses after 24 edges", fb_cnt, 2);

    // Below-minimum words
    fb_word = 12'd0; do_load(); fb_cnt = 0;
    repeat (11) fb_edge(); tick(3);
    check(fb_cnt == 0, "R10", "fb clamp, 11 edges", fb_cnt, 0);
    fb_edge(); tick(3);
    check(fb_cnt == 1, "R10", "fb clamp, 12 edges", fb_cnt, 1);
    ref_sel = 1'b1; osc_word = 7'd0; do_load(); ref_cnt = 0;
    repeat (2) osc_edge(); tick(3);
    check(ref_cnt == 0, "R10", "osc clamp, 2 edges", ref_cnt, 0);
    osc_edge(); tick(3);
    check(ref_cnt == 1, "R10", "osc clamp, 3 edges", ref_cnt, 1);

    // Oscillator divider as reference
    osc_word = 7'd1; do_load(); ref_cnt = 0;
    repeat (9) osc_edge(); tick(3);
    check(ref_cnt == 3, "R3", "ref pulses, M=3, 9 edges", ref_cnt, 3);
    osc_word = 7'd5; do_load(); ref_cnt = 0;
    repeat (14) osc_edge(); tick(3);
    check(ref_cnt == 2, "R3", "ref pulses, M=7, 14 edges", ref_cnt, 2);

    // Source selection
    base = ref_cnt;
    repeat (3) begin hsync = 1'b1; tick(4); hsync = 1'b0; tick(4); end
    check(ref_cnt == base, "R4", "hsync ignored when osc selected", ref_cnt - base, 0);
    ref_sel = 1'b0; do_load(); base = ref_cnt;
    repeat (7) osc_edge(); tick(3);
    check(ref_cnt == base, "R4", "osc ignored when hsync selected", ref_cnt - base, 0);
    hsync = 1'b1; tick(5); hsync = 1'b0; tick(4);
    check(ref_cnt == base + 1, "R4", "hsync edge is reference", ref_cnt - base, 1);

    // Falling polarity on the reference path
    hs_fall = 1'b1; tick(4); base = ref_cnt;
    hsync = 1'b1; tick(5);
    check(ref_cnt == base, "R5", "rising ignored with falling polarity", ref_cnt - base, 0);
    hsync = 1'b0; tick(5);
    check(ref_cnt == base + 1, "R5", "falling edge is reference", ref_cnt - base, 1);
    hs_fall = 1'b0; tick(4);

    // Word changes wait for a load; a load restarts the count
    fb_word = 12'd4; do_load(); fb_cnt = 0;
    repeat (5) fb_edge();
    fb_word = 12'd8;
    repeat (7) fb_edge(); tick(3);
    check(fb_cnt == 1, "R9", "old modulus kept without load", fb_cnt, 1);
    repeat (12) fb_edge(); tick(3);
    check(fb_cnt == 2, "R9", "old modulus still kept", fb_cnt, 2);
    repeat (5) fb_edge();
    do_load(); fb_cnt = 0;
    repeat (15) fb_edge(); tick(3);
    check(fb_cnt == 0, "R9", "full new period after mid-count load", fb_cnt, 0);
    fb_edge(); tick(3);
    check(fb_cnt == 1, "R9", "pulse at 16th edge after load", fb_cnt, 1);

    clear_pfd();
    fb_word = 12'd4; do_load(); tick(4);
    mute = 1'b0;
    phase_event(6, 1'b1, "R6");
    tick(10);
    check(sbq.size() == 0, "R6", "expected pulses left unseen", sbq.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule